// File: doc/BRIEF.md
# Three-Step Code Lock Controller

This block is a clocked door lock that accepts a code as a series of digit entries. Each entry is a 4-bit digit presented together with a single-cycle strobe. The lock compares every strobed digit against the stored code word for the current step. A correct digit moves the lock to the next step. After the last correct digit the door opens. A single wrong digit sends the lock to a trap state, and it stays there until it is reset.

The state register is encoded so that the outputs are taken straight from it. The low bits are a one-hot select that picks the code word for the active step. The top bit is the door-open output. Because of this encoding, no output decode logic is needed. The select drives an AND-OR multiplexer, and the multiplexer feeds a bitwise XNOR-AND comparator. The comparator's equal signal then goes back to the controller. The code words are plain inputs, so loading and holding them is the job of the surrounding logic.

Top module: `combo_lock`

## Requirements
- R1: The 4-bit state is {door_open, step_sel[2:0]}. The first, second and third entry steps read as step_sel = 001, 010 and 100 with door_open = 0. The open state reads as door_open = 1 with step_sel = 000. The error state reads as all zeros. No other value appears.
- R2: When rst = 1 at a rising edge, the next state is the first entry step (step_sel = 001, door_open = 0). This holds from any state and whatever entry_strobe and entry_digit are.
- R3: When entry_strobe = 0 at a rising edge (and rst = 0), the state does not change.
- R4: In entry step k, a strobe with entry_digit equal to code_words[k] moves the lock one step on: 001→010→100→open.
- R5: In any entry step, a strobe with entry_digit different from that step's code word moves the lock to the error state (all zeros).
- R6: The open state and the error state are held until a reset, whatever entry_strobe and entry_digit do.
- R7: Each step compares only against its own word (code_words[0] for step 001, [1] for 010, [2] for 100). A digit that matches a different step's word is a mismatch.
- R8: Both outputs are registered. A strobe sampled at a rising edge shows its effect only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the first entry step |
| entry_strobe | input | 1 | One-cycle pulse marking one digit entry |
| entry_digit | input | 4 | Digit being entered |
| code_words | input | 3x4 | Stored code; element k is the word for step k |
| door_open | output | 1 | 1 only in the open state |
| step_sel | output | 3 | One-hot select of the active step's code word; 000 when open or in error |

## Verification
The bench uses the default parameters: 4-bit digits and three steps. At that size every one of the 16 digit values can be tried at each of the three steps, including values equal to another step's word. The bench also uses codes with repeated digits, idle gaps between strobes, strobes while the lock is open or in error, and reset raised together with a strobe. A behavioural step counter in the bench predicts both outputs, and the bench compares against it on every clock.

// File: rtl/lock_pkg.sv
package lock_pkg;
    parameter int DIGIT_W   = 4;
    parameter int NUM_STEPS = 3;
    localparam int STATE_W  = NUM_STEPS + 1;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [STATE_W-1:0] lock_state_t;

    typedef struct packed {
        logic                 open;
        logic [NUM_STEPS-1:0] sel;
    } lock_out_t;

    localparam lock_state_t ST_FIRST = lock_state_t'(1);
    localparam lock_state_t ST_ERR   = '0;
    localparam lock_state_t ST_OPEN  = lock_state_t'(1) << NUM_STEPS;

    // Entry step: top bit clear, some select bit set.
    function automatic logic is_entry(lock_state_t s);
        return !s[STATE_W-1] && (|s[NUM_STEPS-1:0]);
    endfunction
endpackage

// File: rtl/lock_word_mux.sv
module lock_word_mux #(
    parameter int W = lock_pkg::DIGIT_W,
    parameter int N = lock_pkg::NUM_STEPS
) (
    input  logic [N-1:0]        sel,
    input  logic [N-1:0][W-1:0] words,
    output logic [W-1:0]        y
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [N-1:0] prod;
        for (genvar k = 0; k < N; k++) begin : g_term
            assign prod[k] = words[k][b] & sel[k];
        end
        assign y[b] = |prod;
    end
endmodule

// File: rtl/lock_digit_cmp.sv
module lock_digit_cmp #(
    parameter int W = lock_pkg::DIGIT_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq
);
    logic [W-1:0] bit_same;
    for (genvar i = 0; i < W; i++) begin : g_xnor
        assign bit_same[i] = ~(a[i] ^ b[i]);
    end
    assign eq = &bit_same;
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
    import lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe,
    input  logic        eq,
    output lock_state_t state
);
    lock_state_t state_nx;

    always_comb begin
        state_nx = state;
        if (is_entry(state) && strobe) begin
            state_nx = eq ? (state << 1) : ST_ERR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FIRST;
        else     state <= state_nx;
    end
endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import lock_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              entry_strobe,
    input  logic [DIGIT_W-1:0]                entry_digit,
    input  logic [NUM_STEPS-1:0][DIGIT_W-1:0] code_words,
    output logic                              door_open,
    output logic [NUM_STEPS-1:0]              step_sel
);
    lock_state_t state;
    lock_out_t   outs;
    digit_t      sel_word;
    logic        digit_eq;

    lock_word_mux #(.W(DIGIT_W), .N(NUM_STEPS)) u_mux (
        .sel   (outs.sel),
        .words (code_words),
        .y     (sel_word)
    );

    lock_digit_cmp #(.W(DIGIT_W)) u_cmp (
        .a  (sel_word),
        .b  (entry_digit),
        .eq (digit_eq)
    );

    lock_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .strobe (entry_strobe),
        .eq     (digit_eq),
        .state  (state)
    );

    assign outs      = state;
    assign door_open = outs.open;
    assign step_sel  = outs.sel;
endmodule

// File: rtl/lock_checker.sv
module lock_checker #(
    parameter int N = lock_pkg::NUM_STEPS
) (
    input logic         clk,
    input logic         rst,
    input logic         entry_strobe,
    input logic         digit_eq,
    input logic         door_open,
    input logic [N-1:0] step_sel
);
    localparam logic [N-1:0] SEL_FIRST = N'(1);

    AST_ENCODING_LEGAL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step_sel) && !(door_open && step_sel != '0)); // R1
    AST_RESET_FIRST: assert property (@(posedge clk)
        rst |=> (step_sel == SEL_FIRST && !door_open)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !entry_strobe |=> $stable({door_open, step_sel})); // R3
    AST_MATCH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (entry_strobe && step_sel != '0 && digit_eq) |=>
        ({door_open, step_sel} == ($past({door_open, step_sel}) << 1))); // R4
    AST_MISMATCH_ERR: assert property (@(posedge clk) disable iff (rst)
        (entry_strobe && step_sel != '0 && !digit_eq) |=>
        (step_sel == '0 && !door_open)); // R5
    AST_OPEN_TRAP: assert property (@(posedge clk) disable iff (rst)
        door_open |=> door_open); // R6
    AST_ERR_TRAP: assert property (@(posedge clk) disable iff (rst)
        (step_sel == '0 && !door_open) |=> (step_sel == '0 && !door_open)); // R6
endmodule

bind combo_lock lock_checker #(.N(lock_pkg::NUM_STEPS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .entry_strobe (entry_strobe),
    .digit_eq     (digit_eq),
    .door_open    (door_open),
    .step_sel     (step_sel)
);

// File: tb/combo_lock_tb.sv
module combo_lock_tb;
    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            entry_strobe = 1'b0;
    logic [3:0]      entry_digit = '0;
    logic [2:0][3:0] code_words = '0;
    logic            door_open;
    logic [2:0]      step_sel;

    int    n_checks = 0;
    int    n_errors = 0;
    int    ref_step = 0;   // 0..2 entry, 3 open, 4 error
    bit    finished = 1'b0;
    string phase = "R2";

    always #10 clk = ~clk;   // 50 MHz

    combo_lock u_dut (
        .clk          (clk),
        .rst          (rst),
        .entry_strobe (entry_strobe),
        .entry_digit  (entry_digit),
        .code_words   (code_words),
        .door_open    (door_open),
        .step_sel     (step_sel)
    );

    function automatic logic [3:0] expect_outs(int s);
        if (s < 3)       return {1'b0, 3'(1 << s)};
        else if (s == 3) return 4'b1000;
        else             return 4'b0000;
    endfunction

    task automatic check_outs(string tag);
        logic [3:0] exp_v;
        exp_v = expect_outs(ref_step);
        n_checks++;
        if ({door_open, step_sel} !== exp_v) begin
            n_errors++;
            $display("FAIL %s: {open,sel} actual=%b expected=%b", tag, {door_open, step_sel}, exp_v);
        end
    endtask

    // Drive one cycle, advance the model at the edge, compare after it (R8).
    task automatic tick(logic r, logic s, logic [3:0] d);
        rst          = r;
        entry_strobe = s;
        entry_digit  = d;
        @(posedge clk);
        if (r)                          ref_step = 0;
        else if (s && ref_step < 3)     ref_step = (d == code_words[ref_step]) ? ref_step + 1 : 4;
        @(negedge clk);
        check_outs(phase);
    endtask

    task automatic enter_code();
        for (int k = 0; k < 3; k++) tick(1'b0, 1'b1, code_words[k]);
    endtask

    initial begin
        code_words = {4'h9, 4'h3, 4'h5};
        @(negedge clk);
        phase = "R2";
        tick(1'b1, 1'b0, 4'h0);
        tick(1'b1, 1'b1, 4'h7);
        // idle cycles with changing digits
        phase = "R3";
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 4'(i * 3));
        // full code with idle gaps
        phase = "R4";
        tick(1'b0, 1'b1, 4'h5);
        tick(1'b0, 1'b0, 4'h3);
        tick(1'b0, 1'b1, 4'h3);
        tick(1'b0, 1'b0, 4'h0);
        tick(1'b0, 1'b1, 4'h9);
        phase = "R6";
        for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, 4'(i));
        phase = "R2";
        tick(1'b1, 1'b1, 4'h5);
        tick(1'b0, 1'b0, 4'h0);
        // cross-step digit is a mismatch
        phase = "R7";
        tick(1'b0, 1'b1, 4'h3);
        phase = "R6";
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, code_words[i % 3]);
        // exhaustive digit sweep at every step
        for (int k = 0; k < 3; k++) begin
            for (int v = 0; v < 16; v++) begin
                phase = "R2";
                tick(1'b1, 1'b0, 4'h0);
                phase = "R4";
                for (int j = 0; j < k; j++) tick(1'b0, 1'b1, code_words[j]);
                phase = (v == int'(code_words[k])) ? "R4" : "R5";
                tick(1'b0, 1'b1, 4'(v));
                phase = "R6";
                tick(1'b0, 1'b1, 4'(v));
            end
        end
        // repeated digits in the code
        code_words = {4'hA, 4'hA, 4'hA};
        phase = "R2";
        tick(1'b1, 1'b0, 4'h0);
        phase = "R4";
        enter_code();
        // reset with strobe mid-sequence
        phase = "R2";
        tick(1'b1, 1'b0, 4'h0);
        tick(1'b0, 1'b1, 4'hA);
        tick(1'b1, 1'b1, 4'hB);
        phase = "R5";
        tick(1'b0, 1'b1, 4'hB);
        phase = "R6";
        tick(1'b0, 1'b0, 4'hA);
        // new code, distinct words
        code_words = {4'h0, 4'hF, 4'h1};
        phase = "R2";
        tick(1'b1, 1'b0, 4'h0);
        phase = "R7";
        tick(1'b0, 1'b1, 4'hF);
        phase = "R2";
        tick(1'b1, 1'b0, 4'h0);
        phase = "R4";
        enter_code();
        phase = "R1";
        tick(1'b0, 1'b0, 4'h0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule